// File: doc/BRIEF.md
# MDIO Management Access Controller

This block gives software a register-level path to the management registers of an Ethernet PHY over the two-wire MDIO bus. Software describes one transaction by writing a single packed access word. That word holds the direction, the 5-bit PHY address, the 5-bit register address and, for a write, 16 bits of data. The same write sets the go bit. The controller then serialises a Clause 22 frame on MDC/MDIO. On a read it captures the PHY's reply and an acknowledge flag. It clears go by itself when the frame is over.

A second register holds the enable bit and the MDC divider, and shows whether the sequencer is idle. The sequencer has six states:

- IDLE: waits for go.
- PREAMBLE: sends 32 ones.
- COMMAND: sends start, opcode, PHY address and register address.
- TURNAROUND: two bits.
- DATA: 16 bits.
- FINISH: releases the bus and signals completion.

The state moves on each falling-edge tick of MDC:

- IDLE to PREAMBLE, on go while enabled.
- PREAMBLE to COMMAND, after the 32nd bit.
- COMMAND to TURNAROUND, after the 14th bit.
- TURNAROUND to DATA, after 2 bits.
- DATA to FINISH, after 16 bits.
- FINISH to IDLE, on the next tick.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The access register decodes bit 31 as go, bit 30 as write (1) or read (0), bit 29 as acknowledge (read-only), bits 25:21 as the PHY register address, bits 20:16 as the PHY address and bits 15:0 as data. Reading it returns the stored fields.
- R2: A transaction drives, MSB first: 32 ones, start 01, opcode (01 write, 10 read), the PHY address, the register address and a 2-bit turnaround. For a write, the turnaround is 10 and is followed by the 16 data bits.
- R3: On a read, MDIO is released (output enable low) for both turnaround bits and all 16 data bits. The PHY's 16 data bits are captured MSB first into the data field. Acknowledge is set when the PHY drives the second turnaround bit low.
- R4: If the PHY leaves the second turnaround bit high, acknowledge reads 0 after the read completes. A completed write also leaves acknowledge at 0.
- R5: Go stays 1 while the transaction runs and clears by itself when it completes.
- R6: A write to the access register while go is 1 is ignored. The frame in flight and the stored write bit, addresses and data are unchanged.
- R7: Control bit 30 enables the block. While it is 0, MDC stays low and a pending go starts no frame. Setting it later lets that frame run.
- R8: Control bit 31 reads 0 while a frame is in flight and 1 otherwise.
- R9: MDC has a period of 2×(divider+1) system clocks, where the divider is control bits DIV_W-1:0. MDIO and its output enable change only on MDC falling edges.
- R10: After reset, the control register reads 0x80000000 and the access register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 control, 1 access |
| wr_data | input | 32 | Register write data |
| ctrl_q | output | 32 | Control register readback (idle, enable, divider) |
| access_q | output | 32 | Access register readback |
| mdc | output | 1 | MDIO management clock |
| mdio_o | output | 1 | MDIO data out |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO data in |

## Verification
Three situations are hard to reach from the ports.

- A PHY that stays silent in the turnaround, which must yield a clear acknowledge. The bench PHY model can be told not to drive the second turnaround bit, so the line floats high through turnaround and data.
- A second access-register write that arrives mid-frame. The bench issues this write while a frame is running.
- A go bit that is held while the block is disabled. The bench sets go with the enable off, watches that MDC never toggles, and then enables the block.

In each case a scoreboard checks the frame seen on the bus against the queued expectation.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE, ST_CMD, ST_TA, ST_DATA, ST_FIN
    } mdio_state_e;

    localparam int ACC_GO    = 31;
    localparam int ACC_WR    = 30;
    localparam int ACC_ACK   = 29;
    localparam int ACC_REG   = 21;
    localparam int ACC_PHY   = 16;
    localparam int CTL_IDLE  = 31;
    localparam int CTL_EN    = 30;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int CMD_LEN   = 4 + 2 * ADDR_W;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap      = (cnt >= div);
    assign rise_tick = en && wrap && !mdc;
    assign fall_tick = en && wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_engine.sv
`timescale 1ns/1ps
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output mdio_state_e       state
);
    localparam int CNT_W = ($clog2(PRE_LEN) < 4) ? 4 : $clog2(PRE_LEN);

    mdio_state_e        state_d;
    logic [CNT_W-1:0]   cnt, cnt_d;
    logic [CMD_LEN-1:0] cmd_q;
    logic [DATA_W-1:0]  wdat_q;
    logic               wr_q;
    logic               pend_ack, pend_dat;
    logic [3:0]         cmd_idx, dat_idx;

    assign cmd_idx = 4'(CMD_LEN - 1) - cnt[3:0];
    assign dat_idx = 4'(DATA_W - 1) - cnt[3:0];

    // next-state logic
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        unique case (state)
            ST_IDLE: if (start) begin
                state_d = ST_PRE;
                cnt_d   = '0;
            end
            ST_PRE: if (fall_tick) begin
                if (cnt == CNT_W'(PRE_LEN - 1)) begin
                    state_d = ST_CMD;
                    cnt_d   = '0;
                end else cnt_d = cnt + 1'b1;
            end
            ST_CMD: if (fall_tick) begin
                if (cnt == CNT_W'(CMD_LEN - 1)) begin
                    state_d = ST_TA;
                    cnt_d   = '0;
                end else cnt_d = cnt + 1'b1;
            end
            ST_TA: if (fall_tick) begin
                if (cnt == CNT_W'(1)) begin
                    state_d = ST_DATA;
                    cnt_d   = '0;
                end else cnt_d = cnt + 1'b1;
            end
            ST_DATA: if (fall_tick) begin
                if (cnt == CNT_W'(DATA_W - 1)) begin
                    state_d = ST_FIN;
                    cnt_d   = '0;
                end else cnt_d = cnt + 1'b1;
            end
            ST_FIN: if (fall_tick) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    // outputs: bus drive on falling ticks, capture on rising ticks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_o   <= 1'b1;
            mdio_oe  <= 1'b0;
            done     <= 1'b0;
            ack      <= 1'b0;
            rdata    <= '0;
            pend_ack <= 1'b0;
            pend_dat <= 1'b0;
            cmd_q    <= '0;
            wdat_q   <= '0;
            wr_q     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE && start) begin
                cmd_q  <= {2'b01, is_write ? 2'b01 : 2'b10, phy_addr, reg_addr};
                wdat_q <= wdata;
                wr_q   <= is_write;
                ack    <= 1'b0;
                rdata  <= '0;
            end
            if (fall_tick) begin
                pend_ack <= 1'b0;
                pend_dat <= 1'b0;
                unique case (state)
                    ST_IDLE: begin
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b0;
                    end
                    ST_PRE: begin
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b1;
                    end
                    ST_CMD: begin
                        mdio_o  <= cmd_q[cmd_idx];
                        mdio_oe <= 1'b1;
                    end
                    ST_TA: begin
                        if (wr_q) begin
                            mdio_o  <= (cnt == '0);
                            mdio_oe <= 1'b1;
                        end else begin
                            mdio_o   <= 1'b1;
                            mdio_oe  <= 1'b0;
                            pend_ack <= cnt[0];
                        end
                    end
                    ST_DATA: begin
                        if (wr_q) begin
                            mdio_o  <= wdat_q[dat_idx];
                            mdio_oe <= 1'b1;
                        end else begin
                            mdio_o   <= 1'b1;
                            mdio_oe  <= 1'b0;
                            pend_dat <= 1'b1;
                        end
                    end
                    ST_FIN: begin
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b0;
                        done    <= 1'b1;
                    end
                endcase
            end
            if (rise_tick) begin
                if (pend_ack) ack <= ~mdio_i;
                if (pend_dat) rdata <= {rdata[DATA_W-2:0], mdio_i};
            end
        end
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] ctrl_q,
    output logic [31:0] access_q,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              en_q, go_q, wr_q, ack_q;
    logic [DIV_W-1:0]  div_q;
    logic [ADDR_W-1:0] reg_q, phy_q;
    logic [DATA_W-1:0] data_q;
    logic              rise_tick, fall_tick, start;
    logic              eng_done, eng_ack;
    logic [DATA_W-1:0] eng_rdata;
    mdio_state_e       eng_state;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[29:26], wr_data[29:DIV_W]};

    assign start = go_q && en_q && !eng_done && (eng_state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            div_q  <= '0;
            go_q   <= 1'b0;
            wr_q   <= 1'b0;
            ack_q  <= 1'b0;
            reg_q  <= '0;
            phy_q  <= '0;
            data_q <= '0;
        end else begin
            if (wr_en && !wr_sel) begin
                en_q  <= wr_data[CTL_EN];
                div_q <= wr_data[DIV_W-1:0];
            end
            if (eng_done) begin
                go_q  <= 1'b0;
                ack_q <= !wr_q && eng_ack;
                if (!wr_q) data_q <= eng_rdata;
            end else if (wr_en && wr_sel && !go_q) begin
                go_q   <= wr_data[ACC_GO];
                wr_q   <= wr_data[ACC_WR];
                ack_q  <= 1'b0;
                reg_q  <= wr_data[ACC_REG +: ADDR_W];
                phy_q  <= wr_data[ACC_PHY +: ADDR_W];
                data_q <= wr_data[DATA_W-1:0];
            end
        end
    end

    assign ctrl_q   = {(eng_state == ST_IDLE), en_q, {(30-DIV_W){1'b0}}, div_q};
    assign access_q = {go_q, wr_q, ack_q, 3'b000, reg_q, phy_q, data_q};

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_q),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_engine #(.PRE_LEN(PRE_LEN)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .is_write  (wr_q),
        .phy_addr  (phy_q),
        .reg_addr  (reg_q),
        .wdata     (data_q),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (eng_done),
        .ack       (eng_ack),
        .rdata     (eng_rdata),
        .state     (eng_state)
    );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_chk
    import mdio_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        idle,
    input logic        en,
    input logic        go,
    input logic [10:0] acc_fields,
    input logic        wr_en,
    input logic        wr_sel,
    input logic        eng_done,
    input mdio_state_e eng_state
);
    AST_BUSY_HAS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> go); // R8
    AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_o != $past(mdio_o) || mdio_oe != $past(mdio_oe)) |-> $fell(mdc)); // R9
    AST_DISABLED_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc); // R7
    AST_GO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !go); // R5
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && go && !eng_done) |=> $stable(acc_fields)); // R6
    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == ST_DATA && !acc_fields[10]) |-> !mdio_oe); // R3
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .idle       (ctrl_q[31]),
    .en         (ctrl_q[30]),
    .go         (access_q[31]),
    .acc_fields ({access_q[30], access_q[25:16]}),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .eng_done   (eng_done),
    .eng_state  (eng_state)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_q, access_q;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int mdc_edges = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mdio_mgmt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ctrl_q(ctrl_q), .access_q(access_q),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard: {wr, phy[4:0], reg[4:0], data[15:0]}
    logic [26:0] exp_q[$];
    int          bitn = 0;
    logic [63:0] frame, oemap;
    bit          is_rd = 0;
    bit          resp_ack = 1;
    logic [15:0] resp_data = '0;

    // PHY model and monitor
    always @(posedge mdc) begin
        mdc_edges++;
        if (bitn != 0 || mdio_oe) begin
            frame[63-bitn] = mdio_o;
            oemap[63-bitn] = mdio_oe;
            if (bitn == 35) is_rd = (frame[29:28] == 2'b10);
            if (bitn == 63) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2 unexpected frame", frame, 64'd0);
                end else begin
                    logic [26:0] it;
                    logic [45:0] hdr;
                    it  = exp_q.pop_front();
                    hdr = {32'hFFFF_FFFF, 2'b01, it[26] ? 2'b01 : 2'b10,
                           it[25:21], it[20:16]};
                    check(frame[63:18] == hdr, "R2/R1 header fields",
                          {18'd0, frame[63:18]}, {18'd0, hdr});
                    if (it[26])
                        check(frame[17:0] == {2'b10, it[15:0]} && oemap == '1,
                              "R2 write turnaround and data",
                              {46'd0, frame[17:0]}, {46'd0, 2'b10, it[15:0]});
                    else
                        check(oemap[17:0] == '0 && oemap[63:18] == '1,
                              "R3 bus released in read", oemap, {46'h3FFF_FFFF_FFFF, 18'd0});
                end
                bitn  = 0;
                is_rd = 0;
            end else begin
                bitn++;
            end
        end
    end

    always @(negedge mdc) begin
        if (is_rd && resp_ack && bitn == 47)                   mdio_i = 1'b0;
        else if (is_rd && resp_ack && bitn >= 48 && bitn <= 63) mdio_i = resp_data[63-bitn];
        else                                                   mdio_i = 1'b1;
    end

    task automatic bus_wr(input bit sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_go_clear();
        for (int i = 0; i < 20000 && access_q[31]; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] acc_word(bit wr, logic [4:0] phy,
                                             logic [4:0] rg, logic [15:0] d);
        return {1'b1, wr, 4'b0000, rg, phy, d};
    endfunction

    // driver: queue expectation, launch access
    task automatic launch(bit wr, logic [4:0] phy, logic [4:0] rg,
                          logic [15:0] d, bit pack, logic [15:0] pdata);
        resp_ack  = pack;
        resp_data = pdata;
        exp_q.push_back({wr, phy, rg, wr ? d : 16'h0000});
        bus_wr(1'b1, acc_word(wr, phy, rg, d));
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        time t0, t1;
        int  e0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ctrl_q == 32'h8000_0000, "R10 control reset", ctrl_q, 32'h8000_0000);
        check(access_q == 32'h0, "R10 access reset", access_q, 32'h0);

        // R9 divider period
        bus_wr(1'b0, 32'h4000_0003);
        @(posedge mdc); t0 = $time;
        @(posedge mdc); t1 = $time;
        check((t1 - t0) == 64, "R9 mdc period div=3", t1 - t0, 64);
        bus_wr(1'b0, 32'h4000_0001);
        @(posedge mdc); t0 = $time;
        @(posedge mdc); t1 = $time;
        check((t1 - t0) == 32, "R9 mdc period div=1", t1 - t0, 32);

        // R2 write, R8 idle, R5 self clear, R1 readback
        launch(1'b1, 5'd5, 5'h12, 16'hA5C3, 1'b1, 16'h0);
        repeat (3) @(negedge clk);
        check(ctrl_q[31] == 1'b0, "R8 busy shows not idle", ctrl_q[31], 0);
        check(access_q[31] == 1'b1, "R5 go held during frame", access_q[31], 1);
        wait_go_clear();
        repeat (2) @(negedge clk);
        check(access_q[31] == 1'b0, "R5 go cleared", access_q[31], 0);
        check(ctrl_q[31] == 1'b1, "R8 idle after frame", ctrl_q[31], 1);
        check(access_q[30:0] == {1'b1, 4'b0000, 5'h12, 5'd5, 16'hA5C3},
              "R1 R4 readback after write", access_q, {1'b1, 4'b0000, 5'h12, 5'd5, 16'hA5C3});

        // R3 read with acknowledge
        launch(1'b0, 5'd17, 5'h03, 16'h0000, 1'b1, 16'h3C5A);
        wait_go_clear();
        @(negedge clk);
        check(access_q[29] == 1'b1, "R3 ack on read", access_q[29], 1);
        check(access_q[15:0] == 16'h3C5A, "R3 read data", access_q[15:0], 16'h3C5A);

        // R4 silent PHY
        launch(1'b0, 5'd30, 5'h1F, 16'h0000, 1'b0, 16'h0);
        wait_go_clear();
        @(negedge clk);
        check(access_q[29] == 1'b0, "R4 no ack when silent", access_q[29], 0);

        // R6 write while busy is ignored
        launch(1'b1, 5'd9, 5'h0A, 16'h1234, 1'b1, 16'h0);
        repeat (40) @(negedge clk);
        bus_wr(1'b1, acc_word(1'b0, 5'd1, 5'h01, 16'hFFFF));
        @(negedge clk);
        check(access_q[30:0] == {1'b1, 4'b0000, 5'h0A, 5'd9, 16'h1234},
              "R6 fields kept mid-frame", access_q, {1'b1, 4'b0000, 5'h0A, 5'd9, 16'h1234});
        wait_go_clear();
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R6 only original frame seen", exp_q.size(), 0);
        check(access_q[31] == 1'b0, "R6 busy write did not rearm go", access_q[31], 0);

        // R7 disabled block holds go
        bus_wr(1'b0, 32'h0000_0001);
        launch(1'b1, 5'd2, 5'h04, 16'h00F0, 1'b1, 16'h0);
        e0 = mdc_edges;
        repeat (200) @(negedge clk);
        check(mdc_edges == e0, "R7 mdc quiet when disabled", mdc_edges - e0, 0);
        check(ctrl_q[31] == 1'b1 && access_q[31] == 1'b1, "R7 go pending, idle",
              {ctrl_q[31], access_q[31]}, 2'b11);
        bus_wr(1'b0, 32'h4000_0001);
        wait_go_clear();
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0 && access_q[31] == 1'b0, "R7 frame runs after enable",
              exp_q.size(), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule